// File: doc/BRIEF.md
# SPI Banked Register Command Decoder

This block is the command front end of a serial-attached peripheral. It takes the bit stream of an SPI slave, one sampled bit per strobe, while chip select is low. It assembles bytes and interprets the first byte of each transaction as a command. That byte carries a 3-bit operation and a 5-bit register address. The block then gives access to a banked register space and to a byte-stream buffer. The register space is 32 addresses wide. The top five addresses are the same in every bank. The lower 27 are steered into one of four banks by two bits of a control register, which the block holds itself.

The register contents other than the bank-holding control register live outside this block. The decoder reaches them through an address, a bank number, a combinational read-data input and single-cycle read and write strobes. Bit-set and bit-clear commands are performed as a read-modify-write through that port. A class of slow registers (the MAC and MII group) answers a read with a dummy byte first. The buffer is reached through two streaming handshakes, one per direction. A soft-reset command pulses an output and returns the control register to its reset value.

Bit strobes are assumed to arrive at least two clock cycles apart, as an edge detector on a synchronised serial clock produces them. The block acts on each completed byte in the clock cycle after that byte's last bit.

Top module: `spi_bank_cmd_dec`

## Requirements
- R1: The first byte of a transaction holds the operation in bits 7:5 and the address in bits 4:0. Operation 000 reads a register, 010 writes one, 100 sets bits and 101 clears bits. The whole bytes 0x3A, 0x7A and 0xFF mean buffer read, buffer write and soft reset. Any other first byte makes the rest of the transaction produce no strobe.
- R2: Addresses 0x1B to 0x1F reach the same register whatever bank is selected, and `reg_common` is high for them. Address 0x1F is the internal control register and never raises `reg_rd_stb` or `reg_wr_stb`.
- R3: Bits 1:0 of the control register give the bank number on `reg_bank`. That bank number applies to addresses 0x00 to 0x1A.
- R4: A read of an ordinary register returns its value in the first data byte, MSB first. An external read raises `reg_rd_stb` for one cycle.
- R5: The MAC/MII class is addresses 0x00 to 0x1A in bank 2, and addresses 0x00 to 0x05 and 0x0A in bank 3. A read of this class returns 0x00 in the first data byte and the register value in the second.
- R6: A register write stores the first data byte. Later bytes of the same transaction are ignored.
- R7: Bit-set writes the register OR the data byte. Bit-clear writes the register AND the inverted data byte. Both apply to ordinary registers, including the control register.
- R8: Bit-set and bit-clear aimed at a MAC/MII-class register produce no write.
- R9: Buffer read pulses `buf_rd_stb` once when the command byte completes and once when each data byte completes. Each pulse loads the current `buf_rd_data` as the next byte shifted out, for as long as chip select stays low.
- R10: Buffer write pulses `buf_wr_stb` with `buf_wr_data` equal to each completed data byte, for as long as chip select stays low.
- R11: Soft reset pulses `soft_rst` for one cycle. It returns the control register to zero, so bank 0 is selected.
- R12: Chip select going high discards a partially received byte. The next transaction starts again at the command byte, and `miso` is 0 from the cycle after chip select goes high.
- R13: After reset `miso` is 0, `reg_bank` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, already synchronised |
| bit_stb | input | 1 | One-cycle pulse per serial bit sampling edge |
| mosi | input | 1 | Serial data in, sampled on `bit_stb` |
| miso | output | 1 | Serial data out, MSB first, shifts after each `bit_stb` |
| reg_bank | output | 2 | Selected bank number |
| reg_addr | output | 5 | Register address of the current transaction |
| reg_common | output | 1 | Address lies in the bank-independent window |
| reg_rd_stb | output | 1 | External register value taken this cycle |
| reg_rdata | input | 8 | Combinational value of the addressed register |
| reg_wr_stb | output | 1 | Write `reg_wdata` to the addressed register |
| reg_wdata | output | 8 | Write data |
| buf_rd_stb | output | 1 | Buffer byte taken, advance read pointer |
| buf_rd_data | input | 8 | Byte at the buffer read pointer |
| buf_wr_stb | output | 1 | Buffer byte written |
| buf_wr_data | output | 8 | Buffer write data |
| soft_rst | output | 1 | One-cycle soft reset pulse to the device |

## Verification
The bench builds the block with its default parameters. These are a common window starting at 0x1B, the control register at 0x1F and a control reset value of zero. With these values all four banks, the whole common window and both read latencies can be reached from the serial side. The random phase mixes writes, bit operations and reads across every address, and it changes the bank through the control register. Because of that, bank steering and the MAC/MII class boundary get tested against an independent model. Directed transactions cover buffer streaming in both directions, soft reset, ignored first bytes and an aborted partial byte.

// File: rtl/spicmd_pkg.sv
// Shared widths, command encodings and register-class rules for the
// banked SPI command decoder. Assumes 8-bit serial bytes, MSB first.
package spicmd_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int OP_W   = BYTE_W - ADDR_W;
    localparam int BANK_W = 2;
    localparam int CNT_W  = $clog2(BYTE_W);

    // Operation field values (bits 7:5 of the command byte)
    localparam logic [OP_W-1:0] OP_RDREG = 3'b000;
    localparam logic [OP_W-1:0] OP_WRREG = 3'b010;
    localparam logic [OP_W-1:0] OP_SETB  = 3'b100;
    localparam logic [OP_W-1:0] OP_CLRB  = 3'b101;

    // Whole-byte commands
    localparam logic [BYTE_W-1:0] CMD_BUF_RD = 8'h3A;
    localparam logic [BYTE_W-1:0] CMD_BUF_WR = 8'h7A;
    localparam logic [BYTE_W-1:0] CMD_SRST   = 8'hFF;

    typedef enum logic [3:0] {
        PH_CMD,      // waiting for the command byte
        PH_RD_WAIT,  // slow read: dummy byte going out
        PH_WR,       // expecting write data
        PH_SET,      // expecting bit-set mask
        PH_CLR,      // expecting bit-clear mask
        PH_BUF_RD,   // streaming from buffer
        PH_BUF_WR,   // streaming into buffer
        PH_IDLE      // rest of transaction ignored
    } phase_t;

    // Registers that answer a read with a leading dummy byte
    function automatic logic slow_class(input logic [BANK_W-1:0] bank,
                                        input logic [ADDR_W-1:0] addr);
        logic banked;
        banked = (addr <= 5'h1A);
        case (bank)
            2'd2:    slow_class = banked;
            2'd3:    slow_class = banked && ((addr <= 5'h05) || (addr == 5'h0A));
            default: slow_class = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
// Serial byte assembler and transmit shifter.
// Assumes bit_stb marks the sampling edge and is at least two cycles apart;
// a load request from the sequencer never coincides with bit_stb.
module spi_byte_shifter
    import spicmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              bit_stb,
    input  logic              mosi,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_val,
    output logic              miso,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;

    assign byte_val  = {rx_sr[BYTE_W-2:0], mosi};
    assign byte_done = !cs_n && bit_stb && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign miso      = tx_sr[BYTE_W-1];

    // Shift registers and bit position; chip select high flushes everything
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else begin
            if (bit_stb) begin
                bit_cnt <= (bit_cnt == CNT_W'(BYTE_W - 1)) ? '0 : bit_cnt + 1'b1;
                rx_sr   <= byte_val;
            end
            if (load_en) begin
                tx_sr <= load_val;
            end else if (bit_stb) begin
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/bank_ctl_reg.sv
// Common control register whose low bits select the active bank.
// Assumes clear and write never need to be merged; clear wins.
module bank_ctl_reg
    import spicmd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_val,
    output logic [BYTE_W-1:0] ctl,
    output logic [BANK_W-1:0] bank
);

    assign bank = ctl[BANK_W-1:0];

    // Hold control value; reset and soft reset restore the reset value
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ctl <= RST_VAL;
        end else if (wr_en) begin
            ctl <= wr_val;
        end
    end

endmodule

// File: rtl/cmd_sequencer.sv
// Transaction sequencer: latches the address on the command byte, then acts
// on each completed byte one cycle later, when reg_rdata for the latched
// address is valid. Assumes reg_rdata is a combinational function of
// reg_bank/reg_addr.
module cmd_sequencer
    import spicmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] COMMON_BASE = 5'h1B,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 5'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [BANK_W-1:0] bank,
    input  logic [BYTE_W-1:0] ctl,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic [BYTE_W-1:0] buf_rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              common,
    output logic              load_en,
    output logic [BYTE_W-1:0] load_val,
    output logic              reg_rd_stb,
    output logic              reg_wr_stb,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              ctl_wr_en,
    output logic [BYTE_W-1:0] ctl_wr_val,
    output logic              buf_rd_stb,
    output logic              buf_wr_stb,
    output logic [BYTE_W-1:0] buf_wr_data,
    output logic              soft_rst
);

    phase_t            phase, phase_nxt;
    logic              pend;
    logic [BYTE_W-1:0] pbyte;
    logic              is_ctl;
    logic              slow;
    logic [BYTE_W-1:0] rd_val;
    logic              wr_req;
    logic [BYTE_W-1:0] wr_val;
    logic [OP_W-1:0]   op;

    assign is_ctl = (addr == CTRL_ADDR);
    assign common = (addr >= COMMON_BASE);
    assign slow   = !common && slow_class(bank, addr);
    assign rd_val = is_ctl ? ctl : reg_rdata;
    assign op     = pbyte[BYTE_W-1:ADDR_W];

    // Byte capture, address latch and phase advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CMD;
            addr  <= '0;
            pend  <= 1'b0;
            pbyte <= '0;
        end else begin
            pend <= byte_done;
            if (byte_done) begin
                pbyte <= byte_val;
            end
            if (byte_done && phase == PH_CMD) begin
                addr <= byte_val[ADDR_W-1:0];
            end
            if (cs_n) begin
                phase <= PH_CMD;
            end else if (pend) begin
                phase <= phase_nxt;
            end
        end
    end

    // Action for the byte completed in the previous cycle
    always_comb begin
        phase_nxt  = phase;
        load_en    = 1'b0;
        load_val   = '0;
        reg_rd_stb = 1'b0;
        buf_rd_stb = 1'b0;
        buf_wr_stb = 1'b0;
        soft_rst   = 1'b0;
        wr_req     = 1'b0;
        wr_val     = pbyte;
        if (pend) begin
            case (phase)
                PH_CMD: begin
                    if (pbyte == CMD_BUF_RD) begin
                        load_en    = 1'b1;
                        load_val   = buf_rd_data;
                        buf_rd_stb = 1'b1;
                        phase_nxt  = PH_BUF_RD;
                    end else if (pbyte == CMD_BUF_WR) begin
                        phase_nxt = PH_BUF_WR;
                    end else if (pbyte == CMD_SRST) begin
                        soft_rst  = 1'b1;
                        phase_nxt = PH_IDLE;
                    end else begin
                        case (op)
                            OP_RDREG: begin
                                load_en = 1'b1;
                                if (slow) begin
                                    load_val  = '0;
                                    phase_nxt = PH_RD_WAIT;
                                end else begin
                                    load_val   = rd_val;
                                    reg_rd_stb = !is_ctl;
                                    phase_nxt  = PH_IDLE;
                                end
                            end
                            OP_WRREG: phase_nxt = PH_WR;
                            OP_SETB:  phase_nxt = PH_SET;
                            OP_CLRB:  phase_nxt = PH_CLR;
                            default:  phase_nxt = PH_IDLE;
                        endcase
                    end
                end
                PH_RD_WAIT: begin
                    load_en    = 1'b1;
                    load_val   = rd_val;
                    reg_rd_stb = !is_ctl;
                    phase_nxt  = PH_IDLE;
                end
                PH_WR: begin
                    wr_req    = 1'b1;
                    wr_val    = pbyte;
                    phase_nxt = PH_IDLE;
                end
                PH_SET: begin
                    wr_req    = !slow;
                    wr_val    = rd_val | pbyte;
                    phase_nxt = PH_IDLE;
                end
                PH_CLR: begin
                    wr_req    = !slow;
                    wr_val    = rd_val & ~pbyte;
                    phase_nxt = PH_IDLE;
                end
                PH_BUF_RD: begin
                    load_en    = 1'b1;
                    load_val   = buf_rd_data;
                    buf_rd_stb = 1'b1;
                end
                PH_BUF_WR: begin
                    buf_wr_stb = 1'b1;
                end
                default: phase_nxt = PH_IDLE;
            endcase
        end
    end

    // Route register writes to the internal control register or outside
    always_comb begin
        ctl_wr_en   = wr_req && is_ctl;
        ctl_wr_val  = wr_val;
        reg_wr_stb  = wr_req && !is_ctl;
        reg_wdata   = wr_val;
        buf_wr_data = pbyte;
    end

endmodule

// File: rtl/spi_bank_cmd_dec.sv
// Top of the banked SPI command decoder: byte shifter, sequencer and the
// bank-holding control register. Assumes cs_n and bit_stb are synchronous
// to clk and bit_stb pulses are at least two cycles apart.
module spi_bank_cmd_dec
    import spicmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] COMMON_BASE = 5'h1B,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 5'h1F,
    parameter logic [BYTE_W-1:0] CTRL_RST    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              bit_stb,
    input  logic              mosi,
    output logic              miso,
    output logic [BANK_W-1:0] reg_bank,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_common,
    output logic              reg_rd_stb,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              reg_wr_stb,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              buf_rd_stb,
    input  logic [BYTE_W-1:0] buf_rd_data,
    output logic              buf_wr_stb,
    output logic [BYTE_W-1:0] buf_wr_data,
    output logic              soft_rst
);

    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              load_en;
    logic [BYTE_W-1:0] load_val;
    logic              ctl_wr_en;
    logic [BYTE_W-1:0] ctl_wr_val;
    logic [BYTE_W-1:0] ctl;

    spi_byte_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .bit_stb   (bit_stb),
        .mosi      (mosi),
        .load_en   (load_en),
        .load_val  (load_val),
        .miso      (miso),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    cmd_sequencer #(
        .COMMON_BASE (COMMON_BASE),
        .CTRL_ADDR   (CTRL_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .bank        (reg_bank),
        .ctl         (ctl),
        .reg_rdata   (reg_rdata),
        .buf_rd_data (buf_rd_data),
        .addr        (reg_addr),
        .common      (reg_common),
        .load_en     (load_en),
        .load_val    (load_val),
        .reg_rd_stb  (reg_rd_stb),
        .reg_wr_stb  (reg_wr_stb),
        .reg_wdata   (reg_wdata),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_val  (ctl_wr_val),
        .buf_rd_stb  (buf_rd_stb),
        .buf_wr_stb  (buf_wr_stb),
        .buf_wr_data (buf_wr_data),
        .soft_rst    (soft_rst)
    );

    bank_ctl_reg #(
        .RST_VAL (CTRL_RST)
    ) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .wr_en  (ctl_wr_en),
        .wr_val (ctl_wr_val),
        .ctl    (ctl),
        .bank   (reg_bank)
    );

endmodule

// File: rtl/spi_bank_cmd_dec_chk.sv
// Property checker for spi_bank_cmd_dec, attached with bind below.
// Assumes the default-clocked, synchronous active-low reset of the target.
module spi_bank_cmd_dec_chk
    import spicmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h1F,
    parameter logic [BANK_W-1:0] RST_BANK  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              miso,
    input logic [BANK_W-1:0] reg_bank,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_common,
    input logic              reg_rd_stb,
    input logic              reg_wr_stb,
    input logic              buf_rd_stb,
    input logic              buf_wr_stb,
    input logic              soft_rst
);

    logic cs_q;

    // Remember chip select of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd_stb, reg_wr_stb, buf_rd_stb, buf_wr_stb, soft_rst}));

    // R2
    ctl_not_external_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_stb || reg_wr_stb) |-> !(reg_common && reg_addr == CTRL_ADDR));

    // R11
    srst_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (reg_bank == RST_BANK));

    // R12
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso);

    // R12
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cs_q) |-> !(reg_rd_stb || reg_wr_stb || buf_rd_stb || buf_wr_stb || soft_rst));

endmodule

bind spi_bank_cmd_dec spi_bank_cmd_dec_chk #(
    .CTRL_ADDR (CTRL_ADDR),
    .RST_BANK  (CTRL_RST[spicmd_pkg::BANK_W-1:0])
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .miso       (miso),
    .reg_bank   (reg_bank),
    .reg_addr   (reg_addr),
    .reg_common (reg_common),
    .reg_rd_stb (reg_rd_stb),
    .reg_wr_stb (reg_wr_stb),
    .buf_rd_stb (buf_rd_stb),
    .buf_wr_stb (buf_wr_stb),
    .soft_rst   (soft_rst)
);

// File: tb/spi_bank_cmd_dec_test.sv
// Bench: directed corner cases plus seeded random register traffic,
// checked against a bench-side model of the requirements.
module spi_bank_cmd_dec_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       bit_stb = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [1:0] reg_bank;
    logic [4:0] reg_addr;
    logic       reg_common;
    logic       reg_rd_stb;
    logic [7:0] reg_rdata;
    logic       reg_wr_stb;
    logic [7:0] reg_wdata;
    logic       buf_rd_stb;
    logic [7:0] buf_rd_data;
    logic       buf_wr_stb;
    logic [7:0] buf_wr_data;
    logic       soft_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_bank_cmd_dec uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .mosi(mosi),
        .miso(miso), .reg_bank(reg_bank), .reg_addr(reg_addr),
        .reg_common(reg_common), .reg_rd_stb(reg_rd_stb), .reg_rdata(reg_rdata),
        .reg_wr_stb(reg_wr_stb), .reg_wdata(reg_wdata), .buf_rd_stb(buf_rd_stb),
        .buf_rd_data(buf_rd_data), .buf_wr_stb(buf_wr_stb),
        .buf_wr_data(buf_wr_data), .soft_rst(soft_rst)
    );

    function automatic logic [7:0] dinit(input int b, input int a);
        return 8'((b * 53 + a * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] bpat(input int k);
        return 8'((k * 29 + 7) & 255);
    endfunction

    // External device model driven by the decoder's strobes
    logic [7:0] dev [4][32];
    logic [7:0] wlog [64];
    int rp, wp, n_rd, n_wr, n_bwr, n_srst;
    logic [1:0] dbank;

    assign dbank       = reg_common ? 2'd0 : reg_bank;
    assign reg_rdata   = dev[dbank][reg_addr];
    assign buf_rd_data = bpat(rp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++)
                for (int a = 0; a < 32; a++) dev[b][a] <= dinit(b, a);
            rp <= 0; wp <= 0; n_rd <= 0; n_wr <= 0; n_bwr <= 0; n_srst <= 0;
        end else begin
            if (reg_wr_stb) begin
                dev[dbank][reg_addr] <= reg_wdata;
                n_wr <= n_wr + 1;
            end
            if (reg_rd_stb) n_rd <= n_rd + 1;
            if (buf_rd_stb) rp <= rp + 1;
            if (buf_wr_stb) begin
                wlog[wp & 63] <= buf_wr_data;
                wp <= wp + 1;
                n_bwr <= n_bwr + 1;
            end
            if (soft_rst) n_srst <= n_srst + 1;
        end
    end

    // Expected model
    logic [7:0] er [4][32];
    logic [7:0] ectl;
    logic [7:0] mo [8];
    logic [7:0] mi [8];
    int nchk = 0, nfail = 0;
    logic done = 1'b0;

    function automatic logic eslow(input logic [1:0] b, input logic [4:0] a);
        if (a > 5'h1A) return 1'b0;
        if (b == 2'd2) return 1'b1;
        if (b == 2'd3) return (a <= 5'h05) || (a == 5'h0A);
        return 1'b0;
    endfunction

    function automatic int eb(input logic [4:0] a);
        return (a >= 5'h1B) ? 0 : int'(ectl[1:0]);
    endfunction

    function automatic logic [7:0] ecur(input logic [4:0] a);
        return (a == 5'h1F) ? ectl : er[eb(a)][a];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            @(negedge clk); @(negedge clk);
            r[i] = miso;
            bit_stb = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            @(negedge clk); @(negedge clk);
        end
    endtask

    task automatic xact(input int n);
        logic [7:0] t;
        cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sbyte(mo[i], t);
            mi[i] = t;
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] v);
        mo[0] = {3'b010, a}; mo[1] = v; mo[2] = ~v;
        xact(3);
        if (a == 5'h1F) ectl = v; else er[eb(a)][a] = v;
    endtask

    task automatic do_read(input logic [4:0] a, input string req);
        logic [7:0] ev;
        ev = ecur(a);
        mo[0] = {3'b000, a}; mo[1] = 8'($urandom); mo[2] = 8'($urandom);
        xact(3);
        if (eslow(ectl[1:0], a)) begin
            chk({req, " dummy"}, mi[1], 0);
            chk(req, mi[2], ev);
        end else begin
            chk(req, mi[1], ev);
        end
    endtask

    task automatic do_bits(input logic [4:0] a, input logic [7:0] m, input logic clr);
        logic [7:0] nv;
        mo[0] = {clr ? 3'b101 : 3'b100, a}; mo[1] = m;
        nv = clr ? (ecur(a) & ~m) : (ecur(a) | m);
        xact(2);
        if (!eslow(ectl[1:0], a)) begin
            if (a == 5'h1F) ectl = nv; else er[eb(a)][a] = nv;
        end
    endtask

    initial begin
        int pre, pre2, rp0, wp0;
        logic [7:0] t;
        void'($urandom(32'h5EED1));
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) er[b][a] = dinit(b, a);
        ectl = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk("R13 miso", miso, 0);
        chk("R13 bank", reg_bank, 0);
        chk("R13 strobes", {reg_rd_stb, reg_wr_stb, buf_rd_stb, buf_wr_stb, soft_rst}, 0);

        // R4 ordinary read and read strobe
        pre = n_rd;
        do_read(5'h03, "R4");
        chk("R4 rd strobe count", n_rd - pre, 1);

        // R6 write, trailing byte ignored
        pre = n_wr;
        do_write(5'h07, 8'hC3);
        chk("R6 one write", n_wr - pre, 1);
        do_read(5'h07, "R6");

        // R3 bank steering through control register bits 1:0
        do_write(5'h1F, 8'h01);
        chk("R3 bank out", reg_bank, 1);
        do_write(5'h05, 8'h5A);
        do_write(5'h1F, 8'h00);
        do_read(5'h05, "R3 bank0");
        do_write(5'h1F, 8'h01);
        do_read(5'h05, "R3 bank1");

        // R2 common window identical in every bank
        do_write(5'h1C, 8'h96);
        do_write(5'h1F, 8'h03);
        do_read(5'h1C, "R2");
        pre = n_rd;
        do_read(5'h1F, "R2 ctl");
        chk("R2 ctl internal", n_rd - pre, 0);

        // R5 slow class reads
        do_write(5'h1F, 8'h02);
        do_read(5'h10, "R5 bank2");
        do_write(5'h1F, 8'h03);
        do_read(5'h0A, "R5 bank3 0x0A");
        do_read(5'h07, "R5 bank3 ordinary");

        // R8 bit ops on slow class ignored
        pre = n_wr;
        do_bits(5'h02, 8'hFF, 1'b0);
        do_bits(5'h0A, 8'hFF, 1'b1);
        chk("R8 no write", n_wr - pre, 0);
        do_read(5'h02, "R8");

        // R7 set and clear
        do_write(5'h1F, 8'h00);
        do_write(5'h09, 8'h0F);
        do_bits(5'h09, 8'h30, 1'b0);
        do_read(5'h09, "R7 set");
        do_bits(5'h09, 8'h05, 1'b1);
        do_read(5'h09, "R7 clr");
        do_bits(5'h1F, 8'h02, 1'b0);
        chk("R7 ctl set", reg_bank, 2);

        // R9 buffer read stream
        rp0 = rp;
        mo[0] = 8'h3A;
        for (int i = 1; i < 5; i++) mo[i] = 8'($urandom);
        xact(5);
        for (int i = 1; i < 5; i++) chk("R9 data", mi[i], bpat(rp0 + i - 1));
        chk("R9 strobes", rp - rp0, 5);

        // R10 buffer write stream
        wp0 = wp; pre = n_bwr;
        mo[0] = 8'h7A;
        for (int i = 1; i < 5; i++) mo[i] = 8'(8'h40 + i * 17);
        xact(5);
        chk("R10 count", n_bwr - pre, 4);
        for (int i = 1; i < 5; i++) chk("R10 data", wlog[(wp0 + i - 1) & 63], 8'(8'h40 + i * 17));

        // R11 soft reset
        do_write(5'h1F, 8'h83);
        pre = n_srst;
        mo[0] = 8'hFF; mo[1] = 8'h55;
        xact(2);
        ectl = 8'h00;
        chk("R11 pulse", n_srst - pre, 1);
        chk("R11 bank", reg_bank, 0);
        do_read(5'h1F, "R11 ctl");

        // R1 unknown first byte ignored
        pre = n_wr; pre2 = n_rd;
        mo[0] = 8'hC4; mo[1] = 8'hAA; mo[2] = 8'h55;
        xact(3);
        chk("R1 no write", n_wr - pre, 0);
        chk("R1 no read", n_rd - pre2, 0);
        mo[0] = 8'h3B; mo[1] = 8'h11;
        pre = rp;
        xact(2);
        chk("R1 near-buffer byte ignored", rp - pre, 0);

        // R12 partial byte aborted by chip select
        pre = n_wr;
        cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        sbyte({3'b010, 5'h04}, t);
        for (int i = 0; i < 5; i++) begin
            mosi = 1'b1;
            @(negedge clk); @(negedge clk);
            bit_stb = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            @(negedge clk); @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 no write", n_wr - pre, 0);
        chk("R12 miso", miso, 0);
        do_read(5'h04, "R12 restart");

        // Random traffic (R3 R4 R5 R6 R7 R8)
        for (int k = 0; k < 300; k++) begin
            logic [4:0] a;
            int sel;
            a = 5'($urandom);
            sel = int'($urandom % 6);
            case (sel)
                0: do_write(a, 8'($urandom));
                1: do_bits(a, 8'($urandom), 1'b0);
                2: do_bits(a, 8'($urandom), 1'b1);
                3: do_write(5'h1F, 8'($urandom));
                default: do_read(a, "R5 random");
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule